// File: doc/BRIEF.md
# Performance Monitor Cycle Counter

This block is a 64-bit cycle counter with a control register and a filter register. Software reaches all of it through a small register port. The control register turns counting on and off and clears the count. It also picks one of two rates: the counter advances on every clock, or once per 64 clocks through a six-bit prescaler.

The count can be read and written as one 64-bit value. It can also be written through a 32-bit alias that replaces only the low half and leaves the high half alone. Writes to the control register and to the filter register are masked, so only certain bits are stored. The filter register holds its value but has no effect on counting.

The port takes single-cycle write and read strobes and a two-bit address. The address codes are:

| Code | Register |
|------|----------|
| 0 | control |
| 1 | full 64-bit count |
| 2 | 32-bit count alias |
| 3 | filter |

Read data is registered.

Top module: `pmc_cycle_counter`

## Requirements
- R1: While control bit 0 (enable) is 1, the count rises by one on every clock. While it is 0, the count holds and reads return the same value.
- R2: While control bit 3 (divide) is 1 and the counter is enabled, the count rises once per 64 clocks. The prescaler restarts from zero when the divide bit changes value or the count is cleared, so the first increment comes 64 enabled clocks later.
- R3: A write to address 0 with wdata bit 2 set clears the count to zero. Bit 2 is never stored and always reads back as 0.
- R4: A write to address 0 changes only control bits 0, 3, 4 and 5 (mask 0x39). Every other control bit keeps its value.
- R5: After reset, control bits 31:24 equal id_word[31:24] and control bits 23:0 are zero. The count is also zero after reset.
- R6: A write to address 2 replaces count bits 31:0 with wdata[31:0] and leaves count bits 63:32 unchanged.
- R7: A write to address 1 loads the whole 64-bit count from wdata, whether the counter is enabled or disabled.
- R8: A write to address 3 stores only wdata bits 30:25 (mask 0x7E000000). The filter resets to zero and does not change how the counter counts.
- R9: The count wraps from all ones to zero.
- R10: rdata is loaded on the clock edge where rd_en is high and holds at other times. The value read depends on the address:
  - address 0 gives the control register, zero-extended;
  - address 1 gives the full count;
  - address 2 gives count bits 31:0, zero-extended;
  - address 3 gives the filter register, zero-extended.
- R11: In a cycle where a write to address 1 or 2, or a clearing control write, meets an increment, the written value is stored and that increment is lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_word | input | 32 | Identification word; top byte seeds the control reset value |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 2 | Register select (0 control, 1 count, 2 count low alias, 3 filter) |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Registered read data |

## Verification
The bench goes after the case where a count write and an increment land in the same cycle. A design that lets the increment through would read back the written value plus one.

It also writes the alias with nonzero upper data bits. A design that stores the whole 64-bit write through the alias would corrupt the high half.

It writes all ones to the control and filter registers. A missing mask would show stray bits, or bit 2 reading back as set.

Two further tests cover the prescaler and wrap-around. After a divide-mode clear, a prescaler that is not restarted makes the first increment arrive early. Near the top of the count range, a counter that saturates instead of wrapping would stick at all ones.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  localparam int CTRL_W = 32;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 2'd0,
    A_CNT64 = 2'd1,
    A_CNT32 = 2'd2,
    A_FILT  = 2'd3
  } pmc_addr_e;

  localparam logic [CTRL_W-1:0] CTRL_WMASK = 32'h0000_0039;
  localparam logic [CTRL_W-1:0] FILT_WMASK = 32'h7E00_0000;
  localparam int BIT_EN  = 0;
  localparam int BIT_CLR = 2;
  localparam int BIT_DIV = 3;

  function automatic logic [CTRL_W-1:0] ctrl_merge(
      input logic [CTRL_W-1:0] cur, input logic [CTRL_W-1:0] wval);
    return (cur & ~CTRL_WMASK) | (wval & CTRL_WMASK);
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_reset_value(input logic [CTRL_W-1:0] id);
    return {id[CTRL_W-1:CTRL_W-8], {(CTRL_W-8){1'b0}}};
  endfunction

  function automatic logic [CTRL_W-1:0] filt_keep(input logic [CTRL_W-1:0] wval);
    return wval & FILT_WMASK;
  endfunction

endpackage

// File: rtl/pmc_ctrl_regs.sv
module pmc_ctrl_regs
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] id_word,
  input  logic              ctrl_we,
  input  logic              filt_we,
  input  logic [CTRL_W-1:0] wval,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CTRL_W-1:0] filt_q,
  output logic              clear_req,
  output logic              div_change
);

  assign clear_req  = ctrl_we & wval[BIT_CLR];
  assign div_change = ctrl_we & (wval[BIT_DIV] != ctrl_q[BIT_DIV]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= ctrl_reset_value(id_word);
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_merge(ctrl_q, wval);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= '0;
    end else if (filt_we) begin
      filt_q <= filt_keep(wval);
    end
  end

endmodule

// File: rtl/pmc_prescaler.sv
module pmc_prescaler #(
  parameter int DIV_LOG2 = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                divide,
  input  logic                restart,
  output logic [DIV_LOG2-1:0] pre_q,
  output logic                inc_pulse
);

  localparam logic [DIV_LOG2-1:0] TERM = {DIV_LOG2{1'b1}};

  logic at_term;
  assign at_term   = (pre_q == TERM);
  assign inc_pulse = enable & (~divide | at_term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart) begin
      pre_q <= '0;
    end else if (enable && divide) begin
      pre_q <= pre_q + 1'b1;
    end
  end

endmodule

// File: rtl/pmc_count.sv
module pmc_count #(
  parameter int CNT_W = 64,
  parameter int LOW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_full,
  input  logic             load_low,
  input  logic             clear,
  input  logic             inc,
  input  logic [CNT_W-1:0] wval,
  output logic [CNT_W-1:0] count_q
);

  function automatic logic [CNT_W-1:0] low_merge(
      input logic [CNT_W-1:0] cur, input logic [CNT_W-1:0] w);
    return {cur[CNT_W-1:LOW_W], w[LOW_W-1:0]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (load_full) begin
      count_q <= wval;
    end else if (load_low) begin
      count_q <= low_merge(count_q, wval);
    end else if (clear) begin
      count_q <= '0;
    end else if (inc) begin
      count_q <= count_q + 1'b1;
    end
  end

endmodule

// File: rtl/pmc_cycle_counter.sv
module pmc_cycle_counter
  import pmc_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int LOW_W    = 32,
  parameter int DIV_LOG2 = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] id_word,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata
);

  localparam int PAD_CTRL = CNT_W - CTRL_W;
  localparam int PAD_LOW  = CNT_W - LOW_W;

  logic [CTRL_W-1:0]   ctrl_q;
  logic [CTRL_W-1:0]   filt_q;
  logic [CNT_W-1:0]    count_q;
  logic [DIV_LOG2-1:0] pre_q;
  logic                inc_pulse;
  logic                clear_req;
  logic                div_change;
  logic                wr_ctrl, wr_full, wr_low, wr_filt;
  logic                cnt_sw_write;

  assign wr_ctrl = wr_en & (addr == A_CTRL);
  assign wr_full = wr_en & (addr == A_CNT64);
  assign wr_low  = wr_en & (addr == A_CNT32);
  assign wr_filt = wr_en & (addr == A_FILT);
  assign cnt_sw_write = wr_full | wr_low | clear_req;

  pmc_ctrl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_word    (id_word),
    .ctrl_we    (wr_ctrl),
    .filt_we    (wr_filt),
    .wval       (wdata[CTRL_W-1:0]),
    .ctrl_q     (ctrl_q),
    .filt_q     (filt_q),
    .clear_req  (clear_req),
    .div_change (div_change)
  );

  pmc_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (ctrl_q[BIT_EN]),
    .divide    (ctrl_q[BIT_DIV]),
    .restart   (clear_req | div_change),
    .pre_q     (pre_q),
    .inc_pulse (inc_pulse)
  );

  pmc_count #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_full (wr_full),
    .load_low  (wr_low),
    .clear     (clear_req),
    .inc       (inc_pulse),
    .wval      (wdata),
    .count_q   (count_q)
  );

  logic [CNT_W-1:0] rd_mux;
  always_comb begin
    unique case (addr)
      A_CTRL:  rd_mux = {{PAD_CTRL{1'b0}}, ctrl_q};
      A_CNT64: rd_mux = count_q;
      A_CNT32: rd_mux = {{PAD_LOW{1'b0}}, count_q[LOW_W-1:0]};
      default: rd_mux = {{PAD_CTRL{1'b0}}, filt_q};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/pmc_cycle_counter_chk.sv
module pmc_cycle_counter_chk
  import pmc_pkg::*;
#(
  parameter int CNT_W    = 64,
  parameter int DIV_LOG2 = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [CNT_W-1:0]    wdata,
  input logic [CNT_W-1:0]    rdata,
  input logic [CTRL_W-1:0]   ctrl_q,
  input logic [CTRL_W-1:0]   filt_q,
  input logic [CNT_W-1:0]    count_q,
  input logic [DIV_LOG2-1:0] pre_q,
  input logic                inc_pulse,
  input logic                cnt_sw_write
);

  p_count_every_clk_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[BIT_EN] && !ctrl_q[BIT_DIV] && !cnt_sw_write) |=> count_q == $past(count_q) + 1'b1);

  p_hold_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[BIT_EN] && !cnt_sw_write) |=> $stable(count_q));

  p_div_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[BIT_EN] && ctrl_q[BIT_DIV] && pre_q != {DIV_LOG2{1'b1}} && !cnt_sw_write)
      |=> $stable(count_q));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTRL && wdata[BIT_CLR]) |=> (count_q == '0 && !ctrl_q[BIT_CLR]));

  p_ctrl_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTRL) |=> (ctrl_q & ~CTRL_WMASK) == ($past(ctrl_q) & ~CTRL_WMASK));

  p_alias_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CNT32)
      |=> (count_q[CNT_W-1:32] == $past(count_q[CNT_W-1:32]) && count_q[31:0] == $past(wdata[31:0])));

  // R11: the write value wins over a coinciding increment
  p_full_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CNT64) |=> count_q == $past(wdata));

  p_filter_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q & ~FILT_WMASK) == '0);

  p_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == {CNT_W{1'b1}} && inc_pulse && !cnt_sw_write) |=> count_q == '0);

  p_read_ctrl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CTRL) |=> rdata == {{(CNT_W-CTRL_W){1'b0}}, $past(ctrl_q)});

  p_read_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

bind pmc_cycle_counter pmc_cycle_counter_chk #(.CNT_W(CNT_W), .DIV_LOG2(DIV_LOG2)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .rd_en        (rd_en),
  .addr         (addr),
  .wdata        (wdata),
  .rdata        (rdata),
  .ctrl_q       (ctrl_q),
  .filt_q       (filt_q),
  .count_q      (count_q),
  .pre_q        (pre_q),
  .inc_pulse    (inc_pulse),
  .cnt_sw_write (cnt_sw_write)
);

// File: tb/tb_pmc_cycle_counter.sv
`timescale 1ns/1ps
module tb_pmc_cycle_counter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] id_word = 32'hA5C3_1177;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;

  always #4 clk = ~clk;

  pmc_cycle_counter dut (
    .clk(clk), .rst_n(rst_n), .id_word(id_word), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  int n_run = 0;
  int n_fail = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];
  logic [63:0] last_exp = '0;

  // Independent reference state, evolved once per rising edge.
  logic [31:0] m_ctrl, m_filt;
  logic [63:0] m_cnt;
  int          m_phase;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl  = {id_word[31:24], 24'd0};
      m_filt  = 32'd0;
      m_cnt   = 64'd0;
      m_phase = 0;
    end else begin
      logic tick, wipe, restart;
      if (rd_en) begin
        case (addr)
          2'd0: exp_q.push_back({32'd0, m_ctrl});
          2'd1: exp_q.push_back(m_cnt);
          2'd2: exp_q.push_back({32'd0, m_cnt[31:0]});
          default: exp_q.push_back({32'd0, m_filt});
        endcase
      end
      tick    = m_ctrl[0] && (!m_ctrl[3] || m_phase == 63);
      wipe    = wr_en && addr == 2'd0 && wdata[2];
      restart = wipe || (wr_en && addr == 2'd0 && (wdata[3] != m_ctrl[3]));
      if (wr_en && addr == 2'd1)      m_cnt = wdata;
      else if (wr_en && addr == 2'd2) m_cnt[31:0] = wdata[31:0];
      else if (wipe)                  m_cnt = 64'd0;
      else if (tick)                  m_cnt = m_cnt + 64'd1;
      if (restart)                       m_phase = 0;
      else if (m_ctrl[0] && m_ctrl[3])   m_phase = (m_phase + 1) % 64;
      if (wr_en && addr == 2'd0) begin
        m_ctrl[0] = wdata[0];
        m_ctrl[3] = wdata[3];
        m_ctrl[4] = wdata[4];
        m_ctrl[5] = wdata[5];
      end
      if (wr_en && addr == 2'd3) m_filt = {1'b0, wdata[30:25], 25'd0};
    end
  end

  // Monitor: compare one registered result per read strobe.
  always @(negedge clk) begin
    if (exp_q.size() > 0 && tag_q.size() > 0) begin
      logic [63:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      last_exp = e;
      n_run++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic do_wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic do_rd(input logic [1:0] a, input string t);
    @(negedge clk);
    tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_val(input string t, input logic [63:0] got, input logic [63:0] e);
    n_run++;
    if (got !== e) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", t, got, e);
    end
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R5 reset values
    do_rd(2'd0, "R5 control reset");
    check_val("R5 control top byte", rdata, {32'd0, 8'hA5, 24'd0});
    do_rd(2'd3, "R8 filter reset");
    do_rd(2'd1, "R5 count reset");
    idle(5);
    do_rd(2'd1, "R1 held while disabled");
    // R1 counting
    do_wr(2'd0, 64'h1);
    idle(20);
    do_rd(2'd1, "R1 enabled count");
    do_rd(2'd1, "R1 enabled count again");
    do_wr(2'd0, 64'h0);
    idle(3);
    do_rd(2'd1, "R1 disabled hold a");
    idle(10);
    do_rd(2'd1, "R1 disabled hold b");
    // R3 / R4 with all ones: enable, divide, clear, bits 4 and 5
    do_wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    do_rd(2'd0, "R4 R3 control mask");
    check_val("R4 control all-ones", rdata, {32'd0, 32'hA500_0039});
    do_rd(2'd1, "R3 cleared");
    // R2 divided rate
    idle(150);
    do_rd(2'd1, "R2 divided count");
    idle(64);
    do_rd(2'd1, "R2 divided count later");
    do_wr(2'd0, 64'h1);
    do_rd(2'd0, "R4 control rewrite");
    // R7 / R11 full write while enabled
    do_wr(2'd1, 64'h1234_5678_9ABC_DEF0);
    do_rd(2'd1, "R7 R11 full write enabled");
    // R6 alias
    do_wr(2'd2, 64'hDEAD_BEEF_FFFF_FFF0);
    do_rd(2'd1, "R6 alias low half");
    do_rd(2'd2, "R10 alias read");
    // R7 disabled, R9 wrap
    do_wr(2'd0, 64'h0);
    do_wr(2'd1, 64'hFFFF_FFFF_FFFF_FFFD);
    do_rd(2'd1, "R7 full write disabled");
    check_val("R7 disabled load", rdata, 64'hFFFF_FFFF_FFFF_FFFD);
    do_wr(2'd0, 64'h1);
    idle(5);
    do_rd(2'd1, "R9 wrap");
    // R8 filter
    do_wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    do_rd(2'd3, "R8 filter mask");
    check_val("R8 filter bits", rdata, 64'h0000_0000_7E00_0000);
    idle(7);
    do_rd(2'd1, "R8 filter no effect");
    // R10 hold
    idle(4);
    check_val("R10 rdata hold", rdata, last_exp);
    idle(3);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule